// File: doc/BRIEF.md
# Link-Up Wait Monitor

This block decides whether a PCIe link is usable. It watches the 5-bit training state code that the link controller reports. A start strobe launches one query. The block samples the code once at the start. If the link is not operational, it waits one polling interval and samples again. It stops at the first operational sample, or when the interval budget runs out.

A query ends with a single-cycle `done_o` pulse, and `link_up_o` carries the verdict. The polling interval comes from a prescaler sized by the clock-frequency parameter. A test parameter can shorten the interval. The state code crosses into the block's clock domain through a two-stage synchronizer before any decision is made on it.

Top module: `link_wait_mon`

## Requirements
- R1: While `rst_ni` is low and after it is released, `busy_o`, `done_o` and `link_up_o` are 0.
- R2: A `start_i` high at a clock edge while the block is idle makes `busy_o` 1 from that edge on.
- R3: Only the codes 0x11, 0x12 and 0x14 count as operational. Every other value of the 5-bit code, including 0x15 and 0x16, counts as not operational.
- R4: The code is sampled one cycle after the start is accepted, with no wait before it. An operational sample raises `done_o` with `link_up_o` = 1 one cycle later, which is two cycles after the start edge.
- R5: After a non-operational sample the block waits `TICK_DIV` cycles, then samples again. A link that becomes operational during the wait is reported after the next sample.
- R6: After `POLLS` intervals with no operational sample, `done_o` rises with `link_up_o` = 0, exactly `1 + POLLS*(TICK_DIV+1)` cycles after the start edge.
- R7: `done_o` is high for exactly one cycle, and `busy_o` is 0 in that cycle.
- R8: A `start_i` while `busy_o` is 1 is ignored and does not change the timing of the query in progress.
- R9: The code passes through two flops before it is sampled. A code that changes at the same edge as an accepted start is not seen by the first sample.
- R10: `link_up_o` is cleared when a start is accepted, stays 0 while busy, and holds the last verdict after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a link-status query |
| state_code_i | input | 5 | Training state code from the link controller |
| busy_o | output | 1 | Query in progress |
| done_o | output | 1 | One-cycle end-of-query pulse |
| link_up_o | output | 1 | Verdict, valid with `done_o` and held after it |

## Verification
All 32 state codes are each held steady through a full query. This separates the three operational codes, which answer on the first sample, from the rest, which run out the full interval budget. It also checks the exact timeout latency. A code that turns operational partway through the waiting tells the resample point apart from a one-shot compare. A code that changes at the same edge as the start exposes the synchronizer delay. A second start during a query shows that the query in progress keeps its timing.

// File: rtl/lwm_pkg.sv
package lwm_pkg;
  localparam int CODE_W = 5;

  typedef enum logic [1:0] {PH_IDLE, PH_CHECK, PH_WAIT} phase_e;

  function automatic logic code_is_up(input logic [CODE_W-1:0] c);
    return (c == 5'h11) || (c == 5'h12) || (c == 5'h14);
  endfunction
endpackage

// File: rtl/lwm_sync.sv
module lwm_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lwm_tick.sv
module lwm_tick #(
  parameter int DIV = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = $clog2(DIV > 1 ? DIV : 2);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  AST_TICK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R5
endmodule

// File: rtl/lwm_fsm.sv
module lwm_fsm
  import lwm_pkg::*;
#(
  parameter int POLLS = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              tick_i,
  output logic              tick_clr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              up_o
);
  localparam int PW = $clog2(POLLS + 1);
  localparam logic [PW-1:0] LAST_POLL = PW'(POLLS - 1);

  phase_e        ph_q;
  logic [PW-1:0] polls_q;
  logic          done_q, up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      polls_q <= '0;
      done_q  <= 1'b0;
      up_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q    <= PH_CHECK;
          up_q    <= 1'b0;
          polls_q <= '0;
        end
        PH_CHECK: if (code_is_up(code_i)) begin
          done_q <= 1'b1;
          up_q   <= 1'b1;
          ph_q   <= PH_IDLE;
        end else begin
          ph_q <= PH_WAIT;
        end
        PH_WAIT: if (tick_i) begin
          polls_q <= polls_q + 1'b1;
          if (polls_q == LAST_POLL) begin
            done_q <= 1'b1;
            ph_q   <= PH_IDLE;
          end else begin
            ph_q <= PH_CHECK;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // prescaler restarts on every entry to the wait phase
  assign tick_clr_o = (ph_q != PH_WAIT);
  assign busy_o     = (ph_q != PH_IDLE);
  assign done_o     = done_q;
  assign up_o       = up_q;

  AST_DOWN_AFTER_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !up_q) |-> (polls_q == PW'(POLLS))); // R6
  AST_UP_ONLY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && up_q) |-> $past(code_is_up(code_i))); // R3
  AST_WAIT_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_WAIT && !tick_i) |=> (ph_q == PH_WAIT)); // R5
endmodule

// File: rtl/link_wait_mon.sv
module link_wait_mon
  import lwm_pkg::*;
#(
  parameter int CLK_HZ   = 250_000_000,
  parameter int TICK_DIV = CLK_HZ / 1000,
  parameter int POLLS    = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] state_code_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              link_up_o
);
  logic [CODE_W-1:0] code_sync;
  logic              tick, tick_clr;

  lwm_sync #(.W(CODE_W), .STAGES(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (state_code_i),
    .q_o   (code_sync)
  );

  lwm_tick #(.DIV(TICK_DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tick_clr),
    .tick_o(tick)
  );

  lwm_fsm #(.POLLS(POLLS)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .code_i    (code_sync),
    .tick_i    (tick),
    .tick_clr_o(tick_clr),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .up_o      (link_up_o)
  );

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o)); // R7
  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_UP_LOW_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !link_up_o); // R10
endmodule

// File: tb/test_link_wait_mon.sv
module test_link_wait_mon;
  localparam int DIV   = 8;
  localparam int POLLS = 120;
  localparam int DOWN_LAT = 1 + POLLS * (DIV + 1);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] code = '0;
  logic       busy, done, up;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  link_wait_mon #(.TICK_DIV(DIV), .POLLS(POLLS)) i_link_wait_mon (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .state_code_i(code),
    .busy_o(busy), .done_o(done), .link_up_o(up)
  );

  // behavioural reference
  int   m_ph, m_wc, m_polls;
  logic m_busy, m_done, m_up;
  logic [4:0] m_s1, m_s2;

  function automatic bit op_code(input logic [4:0] c);
    return (c == 5'h11) || (c == 5'h12) || (c == 5'h14);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_wc = 0; m_polls = 0; m_done = 0; m_up = 0;
      m_s1 = '0; m_s2 = '0;
    end else begin
      m_done = 0;
      if (m_ph == 0) begin
        if (start) begin m_ph = 1; m_up = 0; m_polls = 0; end
      end else if (m_ph == 1) begin
        if (op_code(m_s2)) begin m_done = 1; m_up = 1; m_ph = 0; end
        else begin m_ph = 2; m_wc = 0; end
      end else begin
        if (m_wc == DIV - 1) begin
          m_polls++;
          if (m_polls == POLLS) begin m_done = 1; m_ph = 0; end
          else m_ph = 1;
        end else m_wc++;
      end
      m_s2 = m_s1;
      m_s1 = code;
    end
    m_busy = (m_ph != 0);
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 busy vs model", busy, m_busy);
      check("R7 done vs model", done, m_done);
      check("R10 link_up vs model", up, m_up);
    end
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // returns cycles from start edge to done, start already pulsed
  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 4000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic query(input logic [4:0] c, output int lat);
    code = c;
    repeat (3) @(negedge clk);
    pulse_start();
    wait_done(lat);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 1'b0);
    check("R1 done in reset", done, 1'b0);
    check("R1 up in reset", up, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", busy, 1'b0);
    check("R1 up after reset", up, 1'b0);

    // R4: already up, answer without waiting
    code = 5'h11;
    repeat (3) @(negedge clk);
    pulse_start();
    check("R2 busy after start", busy, 1'b1);
    @(negedge clk);
    check("R4 done two cycles after start", done, 1'b1);
    check("R4 up on first sample", up, 1'b1);
    @(negedge clk);
    check("R7 done single cycle", done, 1'b0);
    check("R10 verdict held", up, 1'b1);

    // R3 / R6: every code held steady
    for (int c = 0; c < 32; c++) begin
      query(5'(c), lat);
      check("R3 verdict per code", up, op_code(5'(c)));
      if (op_code(5'(c))) check("R3 up latency", lat == 2, 1'b1);
      else begin
        total++;
        if (lat != DOWN_LAT) begin
          bad++;
          $display("FAIL R6 timeout latency code=%0h: actual=%0d expected=%0d", c, lat, DOWN_LAT);
        end
      end
      @(negedge clk);
    end

    // R8: second start mid-query ignored
    code = 5'h00;
    repeat (3) @(negedge clk);
    pulse_start();
    repeat (4) @(negedge clk);
    pulse_start();
    lat = 6;
    while (!done && lat < 4000) begin @(negedge clk); lat++; end
    total++;
    if (lat != DOWN_LAT) begin
      bad++;
      $display("FAIL R8 latency: actual=%0d expected=%0d", lat, DOWN_LAT);
    end
    check("R8 verdict down", up, 1'b0);
    @(negedge clk);
    check("R8 no restart", busy, 1'b0);

    // R5: link comes up during waiting
    code = 5'h00;
    repeat (3) @(negedge clk);
    pulse_start();
    repeat (20) @(negedge clk);
    code = 5'h12;
    wait_done(lat);
    check("R5 up after resample", up, 1'b1);
    check("R5 before timeout", lat < DOWN_LAT, 1'b1);
    @(negedge clk);

    // R9: code changing with the start is not seen by the first sample
    code = 5'h00;
    repeat (3) @(negedge clk);
    code = 5'h14;
    pulse_start();
    @(negedge clk);
    check("R9 first sample misses new code", done, 1'b0);
    wait_done(lat);
    check("R9 up after one interval", up, 1'b1);
    @(negedge clk);

    // R10: verdict cleared by next start
    code = 5'h15;
    repeat (3) @(negedge clk);
    pulse_start();
    check("R10 up cleared on start", up, 1'b0);
    wait_done(lat);
    check("R10 down verdict L2", up, 1'b0);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule